// File: doc/BRIEF.md
# Half-Integer Pre-Divider with M/N Fractional Rate Stage

This block turns a free-running reference clock into a clock-enable pulse train with a programmable average rate. The rate comes from two stages in cascade. A pre-divider takes a field `h` and passes on `2/(h+1)` of the input cycles, so it can divide by whole numbers and by halves (1.5, 2.5 and so on). After it, an optional M/N accumulator stage keeps `m` of every `n` pre-divider pulses. The result is a fractional ratio whose long-run value is exact.

The settings arrive as plain inputs: the pre-divider field, a two-bit mode, an M value, and an N value stored in inverted form. The effective `n` is rebuilt inside the block as `(~N masked to the counter width) + m`. The block copies a new setting only when it emits an output pulse. The period in progress therefore always completes under the old setting, and no short period appears. Setting the counter width parameter to zero builds the block without the fractional stage.

Top module: `mn_frac_divider`

## Requirements
- R1: While `rst_n` is low, `tick_o` is 0.
- R2: With `h` equal to 0 or 1 and the M/N stage inactive, `tick_o` is high on every cycle.
- R3: With an odd `h` of 3 or more, pulses are spaced exactly `(h+1)/2` cycles apart.
- R4: With an even `h` of 2 or more, every spacing is `floor((h+1)/2)` or `ceil((h+1)/2)` cycles, and the long-run rate is `2/(h+1)` pulses per cycle, within ±2 over a window.
- R5: When mode equals 2 (binary `10`) and the rebuilt `n = (~cfg_n_inv & mask) + cfg_m` is nonzero, the stage emits exactly `m` pulses for every `n` input pulses.
- R6: Mode values 0, 1 and 3, or a rebuilt `n` of 0, bypass the M/N stage, so the rate is that of the pre-divider alone.
- R7: The two stages cascade, and the average rate is `2m / ((h+1) n)` pulses per cycle.
- R8: A change on the configuration inputs takes effect only at an output pulse. The period in progress completes with the old spacing.
- R9: When `MN_W` is 0, the M/N stage does not exist and the mode and M/N inputs have no effect on the rate.
- R10: If the active setting can never produce a pulse (mode 2 with `m` = 0), new settings are accepted on the next cycle, so output resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hdiv | input | HDIV_W | Half-integer pre-divider field `h` |
| cfg_mode | input | 2 | Stage mode; 2 enables the M/N stage |
| cfg_m | input | max(MN_W,1) | M value |
| cfg_n_inv | input | max(MN_W,1) | Bitwise inverse of `(n - m)` |
| tick_o | output | 1 | Registered output clock-enable pulse |

## Verification
The main instance uses `HDIV_W = 5` and `MN_W = 8`. This reaches pre-divider periods up to 16 cycles, with both even and odd `h`, and M/N fractions such as 3/8 and 2/5 with proper inverted encodings. A second instance with `MN_W = 0` is driven by the same pre-divider and mode inputs. It shows that the fractional stage disappears completely and that mode 2 then has no effect. Rates are checked by counting pulses over 3000-cycle windows. Spacings and the handover of settings are checked by measuring the gaps between pulses.

// File: rtl/mn_frac_div_pkg.sv
package mn_frac_div_pkg;
    localparam logic [1:0] MODE_BYPASS = 2'd0;
    localparam logic [1:0] MODE_DUAL   = 2'd2;
endpackage

// File: rtl/mn_half_prediv.sv
module mn_half_prediv #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    input  logic          clr,
    output logic          pulse
);
    localparam int SW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + SW'(2);
        pulse = (sum >= {1'b0, period});
        if (clr)
            st_d.acc = '0;
        else if (pulse)
            st_d.acc = PW'(sum - {1'b0, period});
        else
            st_d.acc = PW'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_pre_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc < period) || $past(!rst_n) || !$stable(period));
endmodule

// File: rtl/mn_frac_stage.sv
module mn_frac_stage #(
    parameter int MN_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_pulse,
    input  logic [MN_W-1:0] m,
    input  logic [MN_W:0]   n,
    input  logic          clr,
    output logic          pulse
);
    localparam int SW = MN_W + 2;

    typedef struct packed {
        logic [MN_W:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [SW-1:0] sum;
    logic          hit;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + SW'(m);
        hit   = (sum >= {1'b0, n});
        pulse = in_pulse && hit;
        if (clr)
            st_d.acc = '0;
        else if (in_pulse)
            st_d.acc = hit ? (MN_W+1)'(sum - {1'b0, n}) : (MN_W+1)'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_mn_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(n) && $stable(m) && $past(st_q.acc < n)) |-> (st_q.acc < n));
endmodule

// File: rtl/mn_frac_divider.sv
module mn_frac_divider
    import mn_frac_div_pkg::*;
#(
    parameter int HDIV_W = 5,
    parameter int MN_W   = 8,
    localparam int MN_PW = (MN_W > 0) ? MN_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HDIV_W-1:0] cfg_hdiv,
    input  logic [1:0]        cfg_mode,
    input  logic [MN_PW-1:0]  cfg_m,
    input  logic [MN_PW-1:0]  cfg_n_inv,
    output logic              tick_o
);
    localparam int PW = HDIV_W + 1;

    typedef struct packed {
        logic [HDIV_W-1:0] hdiv;
        logic [1:0]        mode;
        logic [MN_PW-1:0]  m;
        logic [MN_PW-1:0]  ninv;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic tick;
    } st_t;

    st_t st_d, st_q;
    cfg_t cfg_in;
    logic [PW-1:0] period;
    logic pre_pulse, mn_on, mn_pulse, tick_c, stall, load, clr;

    assign cfg_in = '{hdiv: cfg_hdiv, mode: cfg_mode, m: cfg_m, ninv: cfg_n_inv};
    assign period = (st_q.cfg.hdiv == '0) ? PW'(2) : ({1'b0, st_q.cfg.hdiv} + PW'(1));

    mn_half_prediv #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .period(period), .clr(clr), .pulse(pre_pulse)
    );

    generate
        if (MN_W > 0) begin : g_mn
            logic [MN_W:0] n_val;
            assign n_val = {1'b0, ~st_q.cfg.ninv} + {1'b0, st_q.cfg.m};
            assign mn_on = (st_q.cfg.mode == MODE_DUAL) && (n_val != '0);
            mn_frac_stage #(.MN_W(MN_W)) u_mn (
                .clk(clk), .rst_n(rst_n), .in_pulse(pre_pulse && mn_on),
                .m(st_q.cfg.m), .n(n_val), .clr(clr), .pulse(mn_pulse)
            );
        end else begin : g_no_mn
            assign mn_on    = 1'b0;
            assign mn_pulse = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        tick_c   = pre_pulse && (!mn_on || mn_pulse);
        stall    = mn_on && (st_q.cfg.m == '0);
        load     = tick_c || stall;
        clr      = load && (cfg_in != st_q.cfg);
        if (load) st_d.cfg = cfg_in;
        st_d.tick = tick_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> !tick_o);

    p_bypass_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (period == PW'(2) && !mn_on) |=> tick_o);

    p_min_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && period >= PW'(4)) |=> !tick_o);

    p_hold_until_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.cfg) && !$past(stall) && !$past(!rst_n)) |-> tick_o);
endmodule

// File: tb/mn_frac_divider_bench.sv
module mn_frac_divider_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] hdiv = '0;
    logic [1:0] mode = '0;
    logic [7:0] mval = '0;
    logic [7:0] ninv = '0;
    logic tick_o, tick_nomn;
    int checks = 0;
    int fails  = 0;
    bit done = 0;
    localparam int W = 3000;

    always #5 clk = ~clk;

    mn_frac_divider #(.HDIV_W(5), .MN_W(8)) u_mn_frac_divider (
        .clk(clk), .rst_n(rst_n), .cfg_hdiv(hdiv), .cfg_mode(mode),
        .cfg_m(mval), .cfg_n_inv(ninv), .tick_o(tick_o)
    );

    mn_frac_divider #(.HDIV_W(5), .MN_W(0)) u_nomn (
        .clk(clk), .rst_n(rst_n), .cfg_hdiv(hdiv), .cfg_mode(mode),
        .cfg_m(1'b0), .cfg_n_inv(1'b0), .tick_o(tick_nomn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int h, input int md, input int m, input int n);
        hdiv = 5'(h);
        mode = 2'(md);
        mval = 8'(m);
        ninv = ~8'(n - m);
    endtask

    task automatic measure(input int w, output int cnt, output int cnt2,
                           output int gmin, output int gmax);
        int last;
        last = -1; cnt = 0; cnt2 = 0; gmin = 1000000; gmax = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (tick_nomn) cnt2++;
            if (tick_o) begin
                cnt++;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
    endtask

    function automatic int expect_cnt(input int h, input int m, input int n);
        int p;
        p = (h == 0) ? 2 : h + 1;
        return (2 * W * m) / (p * n);
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 2) && (b - a <= 2);
    endfunction

    task automatic t_reset;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(tick_o == 1'b0, "R1 reset quiet", int'(tick_o), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_bypass;
        int c, c2, gn, gx;
        setcfg(0, 0, 1, 1);
        repeat (50) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(c == W, "R2 h=0 every cycle", c, W);
        setcfg(1, 0, 1, 1);
        repeat (50) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(c == W, "R2 h=1 every cycle", c, W);
    endtask

    task automatic t_odd;
        int c, c2, gn, gx;
        setcfg(7, 0, 1, 1);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(gn == 4 && gx == 4, "R3 even spacing h=7", gx, 4);
        check(near(c, W / 4), "R3 rate h=7", c, W / 4);
    endtask

    task automatic t_even;
        int c, c2, gn, gx;
        setcfg(4, 0, 1, 1);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(gn == 2 && gx == 3, "R4 spacing h=4 min", gn, 2);
        check(near(c, expect_cnt(4, 1, 1)), "R4 rate h=4", c, expect_cnt(4, 1, 1));
    endtask

    task automatic t_frac;
        int c, c2, gn, gx;
        setcfg(0, 2, 3, 8);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(near(c, expect_cnt(0, 3, 8)), "R5 m/n 3/8", c, expect_cnt(0, 3, 8));
        setcfg(0, 2, 5, 5);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(c == W, "R5 m equals n", c, W);
    endtask

    task automatic t_mode_bypass;
        int c, c2, gn, gx;
        setcfg(7, 1, 3, 8);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(near(c, W / 4), "R6 mode 1 bypass", c, W / 4);
        setcfg(7, 3, 3, 8);
        repeat (100) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(near(c, W / 4), "R6 mode 3 bypass", c, W / 4);
    endtask

    task automatic t_cascade;
        int c, c2, gn, gx;
        setcfg(2, 2, 2, 5);
        repeat (200) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(near(c, expect_cnt(2, 2, 5)), "R7 cascade h=2 2/5", c, expect_cnt(2, 2, 5));
    endtask

    task automatic t_nomn;
        int c, c2, gn, gx;
        setcfg(7, 2, 3, 8);
        repeat (200) @(negedge clk);
        measure(W, c, c2, gn, gx);
        check(near(c, expect_cnt(7, 3, 8)), "R7 cascade h=7 3/8", c, expect_cnt(7, 3, 8));
        check(near(c2, W / 4), "R9 no M/N stage ignores mode", c2, W / 4);
    endtask

    task automatic t_handover;
        int g1, g2;
        setcfg(15, 0, 1, 1);
        repeat (100) @(negedge clk);
        while (!tick_o) @(negedge clk);
        setcfg(3, 0, 1, 1);
        g1 = 0;
        do begin @(negedge clk); g1++; end while (!tick_o && g1 < 100);
        g2 = 0;
        do begin @(negedge clk); g2++; end while (!tick_o && g2 < 100);
        check(g1 == 8, "R8 old period completes", g1, 8);
        check(g2 == 2, "R8 new period after pulse", g2, 2);
    endtask

    task automatic t_stall;
        int c, c2, gn, gx;
        setcfg(0, 2, 0, 8);
        repeat (100) @(negedge clk);
        measure(200, c, c2, gn, gx);
        check(c == 0, "R10 m=0 silent", c, 0);
        setcfg(0, 0, 1, 1);
        repeat (5) @(negedge clk);
        measure(200, c, c2, gn, gx);
        check(c == 200, "R10 resumes after stall", c, 200);
    endtask

    initial begin
        t_reset;
        t_bypass;
        t_odd;
        t_even;
        t_frac;
        t_mode_bypass;
        t_cascade;
        t_nomn;
        t_handover;
        t_stall;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    end
endmodule